// File: doc/BRIEF.md
# Fast System Call Segment Loader

This block resolves the processor state produced by a fast kernel-entry or kernel-exit command. A single-cycle request carries the command kind, the protection-mode bit, the current privilege level, a code-selector base register, a stack pointer and instruction pointer held in model-specific registers, and, for the exit command, the count and data general registers. The block checks whether the command is legal. It then produces the new code and stack selectors, complete descriptor-cache images for both segments, the new stack and instruction pointers, and a mask of flag bits to clear. If the command is illegal, it raises an invalid-opcode fault instead.

The block does not read a descriptor table. Both descriptors come from fixed flat-model constants. Both selectors are derived by arithmetic on the one selector-base register. Writing the results back to the register file is left to the surrounding logic.

Control is a two-state machine. `ST_IDLE` waits for a request. On the transition `IDLE->RESOLVE` it captures the operands and picks the pointer sources. In `ST_RESOLVE` the block either publishes the results with a done pulse or raises a fault pulse. It then takes the transition `RESOLVE->IDLE` without condition.

Top module: `fastcall_seg_loader`

## Requirements
- R1: A request sampled at clock edge N produces exactly one of `done_o` or `fault_o`. That signal is high for the single cycle that follows edge N+1.
- R2: Either command faults when `pe_i` is 0, or when `sel_base_i` with bits 1:0 ignored is zero.
- R3: The exit command (`exit_i`=1) also faults when `cpl_i` is nonzero. The entry command (`exit_i`=0) ignores `cpl_i`.
- R4: On entry, the code selector is `sel_base_i` with bits 1:0 cleared. The stack selector is (`sel_base_i`+8) with bits 1:0 cleared, computed modulo 2^SEL_W.
- R5: On exit, the code selector is (`sel_base_i`+16) with bits 1:0 set to 3. The stack selector is the new code selector plus 8. Both are computed modulo 2^SEL_W.
- R6: On entry, `sp_o` and `ip_o` take `msr_sp_i` and `msr_ip_i`. On exit, they take `gpr_cnt_i` and `gpr_dat_i`.
- R7: Each descriptor output is {w3,w2,w1,w0}, with w0 in bits 15:0.
  - w0 = limit[15:0] = 16'hFFFF.
  - w1 = base[15:0] = 0.
  - w2 holds base[23:16] in bits 7:0, the type in bits 11:8, S in bit 12, the DPL in bits 14:13 and P in bit 15.
  - w3 = 16'h00CF. Its bits 3:0 are limit[19:16]. Bit 4 (A) is 0, bit 6 (D/B) is 1, bit 7 (G) is 1, and bits 15:8 (base[31:24]) are 0.
- R8: The code segment has type 11 and the stack segment has type 3, with S=1 and P=1. The DPL is 0 on entry and 3 on exit. This makes w2 equal to 9B00/9300 on entry and FB00/F300 on exit (hex, code/stack).
- R9: `flag_clr_o` is 32'h00030200 after an entry, with bit 17 (VM), bit 16 (RF) and bit 9 (IF) set. It is 0 after an exit.
- R10: A fault leaves every result output unchanged.
- R11: A request that arrives while a command is being resolved has no effect.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_i | input | 1 | Command request, one cycle |
| exit_i | input | 1 | 0 = kernel entry, 1 = kernel exit |
| pe_i | input | 1 | Protected-mode bit |
| cpl_i | input | 2 | Current privilege level |
| sel_base_i | input | SEL_W | Code-selector base register |
| msr_sp_i | input | ADDR_W | Entry stack pointer register |
| msr_ip_i | input | ADDR_W | Entry instruction pointer register |
| gpr_cnt_i | input | ADDR_W | Count register (exit stack pointer) |
| gpr_dat_i | input | ADDR_W | Data register (exit instruction pointer) |
| done_o | output | 1 | Results published |
| fault_o | output | 1 | Invalid-opcode fault |
| code_sel_o | output | SEL_W | New code selector |
| stack_sel_o | output | SEL_W | New stack selector |
| code_desc_o | output | 64 | Code descriptor-cache image |
| stack_desc_o | output | 64 | Stack descriptor-cache image |
| sp_o | output | ADDR_W | New stack pointer |
| ip_o | output | ADDR_W | New instruction pointer |
| flag_clr_o | output | FLAG_W | Flag bits to clear |

## Verification
The bench builds the block with its default parameters: SEL_W=16, ADDR_W=32 and FLAG_W=32. With a 16-bit selector, the selector sums wrap around modulo 65536. Base 16'hFFFC on entry gives a stack selector of 16'h0004. Base 16'hFFF8 on exit gives selectors 16'h000B and 16'h0013. With 32-bit pointers, the bench can use distinct full-width patterns to tell the register sources apart. It also checks that a second request held during resolution leaves both the outputs and the next cycle untouched.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;
    typedef enum logic {ST_IDLE, ST_RESOLVE} fc_state_e;

    localparam int DESC_W      = 64;
    localparam logic [3:0] CODE_TYPE  = 4'd11;
    localparam logic [3:0] STACK_TYPE = 4'd3;
    localparam logic [31:0] FLAT_BASE  = 32'h0;
    localparam logic [19:0] FLAT_LIMIT = 20'hFFFFF;
    localparam logic DESC_S  = 1'b1;
    localparam logic DESC_P  = 1'b1;
    localparam logic DESC_DB = 1'b1;
    localparam logic DESC_G  = 1'b1;
    localparam logic DESC_A  = 1'b0;

    localparam int FLAG_VM_BIT = 17;
    localparam int FLAG_RF_BIT = 16;
    localparam int FLAG_IF_BIT = 9;
endpackage

// File: rtl/fastcall_gate.sv
module fastcall_gate #(
    parameter int SEL_W = 16
) (
    input  logic             exit_cmd,
    input  logic             pe,
    input  logic [1:0]       cpl,
    input  logic [SEL_W-1:0] sel_base,
    output logic             fault
);
    logic sel_null;
    always_comb begin
        sel_null = (sel_base[SEL_W-1:2] == '0);
        fault    = !pe || sel_null || (exit_cmd && (cpl != 2'd0));
    end
endmodule

// File: rtl/fastcall_selgen.sv
module fastcall_selgen #(
    parameter int SEL_W = 16
) (
    input  logic             exit_cmd,
    input  logic [SEL_W-1:0] sel_base,
    output logic [SEL_W-1:0] code_sel,
    output logic [SEL_W-1:0] stack_sel
);
    localparam logic [SEL_W-1:0] STEP8  = SEL_W'(8);
    localparam logic [SEL_W-1:0] STEP16 = SEL_W'(16);

    logic [SEL_W-1:0] plus8, plus16, exit_cs;
    always_comb begin
        plus8   = sel_base + STEP8;
        plus16  = sel_base + STEP16;
        exit_cs = {plus16[SEL_W-1:2], 2'b11};
        if (exit_cmd) begin
            code_sel  = exit_cs;
            stack_sel = exit_cs + STEP8;
        end else begin
            code_sel  = {sel_base[SEL_W-1:2], 2'b00};
            stack_sel = {plus8[SEL_W-1:2], 2'b00};
        end
    end
endmodule

// File: rtl/fastcall_descpack.sv
module fastcall_descpack
    import fastcall_pkg::*;
(
    input  logic [3:0]        seg_type,
    input  logic [1:0]        dpl,
    output logic [DESC_W-1:0] desc
);
    logic [15:0] w0, w1, w2, w3;
    always_comb begin
        w0 = FLAT_LIMIT[15:0];
        w1 = FLAT_BASE[15:0];
        w2 = {DESC_P, dpl, DESC_S, seg_type, FLAT_BASE[23:16]};
        w3 = {FLAT_BASE[31:24], DESC_G, DESC_DB, 1'b0, DESC_A, FLAT_LIMIT[19:16]};
        desc = {w3, w2, w1, w0};
    end
endmodule

// File: rtl/fastcall_seg_loader.sv
module fastcall_seg_loader
    import fastcall_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              exit_i,
    input  logic              pe_i,
    input  logic [1:0]        cpl_i,
    input  logic [SEL_W-1:0]  sel_base_i,
    input  logic [ADDR_W-1:0] msr_sp_i,
    input  logic [ADDR_W-1:0] msr_ip_i,
    input  logic [ADDR_W-1:0] gpr_cnt_i,
    input  logic [ADDR_W-1:0] gpr_dat_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [SEL_W-1:0]  code_sel_o,
    output logic [SEL_W-1:0]  stack_sel_o,
    output logic [DESC_W-1:0] code_desc_o,
    output logic [DESC_W-1:0] stack_desc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] ip_o,
    output logic [FLAG_W-1:0] flag_clr_o
);
    localparam int NSEG = 2;
    localparam logic [FLAG_W-1:0] ENTRY_CLR =
        (FLAG_W'(1) << FLAG_VM_BIT) | (FLAG_W'(1) << FLAG_RF_BIT) | (FLAG_W'(1) << FLAG_IF_BIT);

    fc_state_e state_q, state_d;

    logic              cap_exit, cap_pe;
    logic [1:0]        cap_cpl;
    logic [SEL_W-1:0]  cap_sel;
    logic [ADDR_W-1:0] cap_sp, cap_ip;

    logic              fault_w;
    logic [SEL_W-1:0]  cs_w, ss_w;
    logic [1:0]        dpl_w;
    logic [DESC_W-1:0] desc_w [NSEG];

    fastcall_gate #(.SEL_W(SEL_W)) u_gate (
        .exit_cmd (cap_exit),
        .pe       (cap_pe),
        .cpl      (cap_cpl),
        .sel_base (cap_sel),
        .fault    (fault_w)
    );

    fastcall_selgen #(.SEL_W(SEL_W)) u_selgen (
        .exit_cmd  (cap_exit),
        .sel_base  (cap_sel),
        .code_sel  (cs_w),
        .stack_sel (ss_w)
    );

    assign dpl_w = cap_exit ? 2'd3 : 2'd0;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam logic [3:0] SEG_TYPE = (g == 0) ? CODE_TYPE : STACK_TYPE;
        fastcall_descpack u_pack (
            .seg_type (SEG_TYPE),
            .dpl      (dpl_w),
            .desc     (desc_w[g])
        );
    end

    // state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_i) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_exit     <= 1'b0;
            cap_pe       <= 1'b0;
            cap_cpl      <= '0;
            cap_sel      <= '0;
            cap_sp       <= '0;
            cap_ip       <= '0;
            done_o       <= 1'b0;
            fault_o      <= 1'b0;
            code_sel_o   <= '0;
            stack_sel_o  <= '0;
            code_desc_o  <= '0;
            stack_desc_o <= '0;
            sp_o         <= '0;
            ip_o         <= '0;
            flag_clr_o   <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        cap_exit <= exit_i;
                        cap_pe   <= pe_i;
                        cap_cpl  <= cpl_i;
                        cap_sel  <= sel_base_i;
                        cap_sp   <= exit_i ? gpr_cnt_i : msr_sp_i;
                        cap_ip   <= exit_i ? gpr_dat_i : msr_ip_i;
                    end
                end
                ST_RESOLVE: begin
                    if (fault_w) begin
                        fault_o <= 1'b1;
                    end else begin
                        done_o       <= 1'b1;
                        code_sel_o   <= cs_w;
                        stack_sel_o  <= ss_w;
                        code_desc_o  <= desc_w[0];
                        stack_desc_o <= desc_w[1];
                        sp_o         <= cap_sp;
                        ip_o         <= cap_ip;
                        flag_clr_o   <= cap_exit ? '0 : ENTRY_CLR;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fastcall_seg_loader_chk.sv
module fastcall_seg_loader_chk
    import fastcall_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input fc_state_e         state_q,
    input logic              done_o,
    input logic              fault_o,
    input logic [SEL_W-1:0]  code_sel_o,
    input logic [SEL_W-1:0]  stack_sel_o,
    input logic [DESC_W-1:0] code_desc_o,
    input logic [DESC_W-1:0] stack_desc_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [ADDR_W-1:0] ip_o,
    input logic [FLAG_W-1:0] flag_clr_o
);
    assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    assert_outcome_after_resolve_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |-> $past(state_q == ST_RESOLVE));

    assert_exit_stack_follows_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_sel_o[1:0] == 2'b11) |-> (stack_sel_o == code_sel_o + SEL_W'(8)));

    assert_entry_rpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_sel_o[1:0] != 2'b11) |-> (code_sel_o[1:0] == 2'b00 && stack_sel_o[1:0] == 2'b00));

    assert_flat_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_desc_o[63:48] == 16'h00CF && stack_desc_o[31:0] == 32'h0000FFFF));

    assert_entry_flag_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_desc_o[46:45] == 2'd0) |-> flag_clr_o == FLAG_W'(32'h00030200));

    assert_fault_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(code_sel_o) && $stable(stack_sel_o) && $stable(sp_o)
                     && $stable(ip_o) && $stable(flag_clr_o) && $stable(code_desc_o)));
endmodule

bind fastcall_seg_loader fastcall_seg_loader_chk #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .code_sel_o   (code_sel_o),
    .stack_sel_o  (stack_sel_o),
    .code_desc_o  (code_desc_o),
    .stack_desc_o (stack_desc_o),
    .sp_o         (sp_o),
    .ip_o         (ip_o),
    .flag_clr_o   (flag_clr_o)
);

// File: tb/test_fastcall_seg_loader.sv
module test_fastcall_seg_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, exit_i = 1'b0, pe_i = 1'b0;
    logic [1:0]  cpl_i = '0;
    logic [15:0] sel_base_i = '0;
    logic [31:0] msr_sp_i = '0, msr_ip_i = '0, gpr_cnt_i = '0, gpr_dat_i = '0;
    logic        done_o, fault_o;
    logic [15:0] code_sel_o, stack_sel_o;
    logic [63:0] code_desc_o, stack_desc_o;
    logic [31:0] sp_o, ip_o, flag_clr_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fastcall_seg_loader i_fastcall_seg_loader (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .exit_i(exit_i), .pe_i(pe_i),
        .cpl_i(cpl_i), .sel_base_i(sel_base_i), .msr_sp_i(msr_sp_i), .msr_ip_i(msr_ip_i),
        .gpr_cnt_i(gpr_cnt_i), .gpr_dat_i(gpr_dat_i), .done_o(done_o), .fault_o(fault_o),
        .code_sel_o(code_sel_o), .stack_sel_o(stack_sel_o), .code_desc_o(code_desc_o),
        .stack_desc_o(stack_desc_o), .sp_o(sp_o), .ip_o(ip_o), .flag_clr_o(flag_clr_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ops(input logic ex, input logic pe, input logic [1:0] cpl,
                           input logic [15:0] sel, input logic [31:0] msp, input logic [31:0] mip,
                           input logic [31:0] cnt, input logic [31:0] dat);
        exit_i = ex; pe_i = pe; cpl_i = cpl; sel_base_i = sel;
        msr_sp_i = msp; msr_ip_i = mip; gpr_cnt_i = cnt; gpr_dat_i = dat;
    endtask

    // pulse request at a falling edge, return at the falling edge where the result is visible
    task automatic issue(input logic ex, input logic pe, input logic [1:0] cpl,
                         input logic [15:0] sel, input logic [31:0] msp, input logic [31:0] mip,
                         input logic [31:0] cnt, input logic [31:0] dat);
        set_ops(ex, pe, cpl, sel, msp, mip, cnt, dat);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_ok(input string tag, input logic ex, input logic [15:0] cs,
                             input logic [15:0] ss, input logic [31:0] sp, input logic [31:0] ip);
        logic [15:0] w2c, w2s;
        w2c = ex ? 16'hFB00 : 16'h9B00;
        w2s = ex ? 16'hF300 : 16'h9300;
        chk({tag, " R1 done"}, {63'd0, done_o}, 64'd1);
        chk({tag, " R1 fault"}, {63'd0, fault_o}, 64'd0);
        chk({tag, " R4/R5 code sel"}, {48'd0, code_sel_o}, {48'd0, cs});
        chk({tag, " R4/R5 stack sel"}, {48'd0, stack_sel_o}, {48'd0, ss});
        chk({tag, " R6 sp"}, {32'd0, sp_o}, {32'd0, sp});
        chk({tag, " R6 ip"}, {32'd0, ip_o}, {32'd0, ip});
        chk({tag, " R7 R8 code desc"}, code_desc_o, {16'h00CF, w2c, 16'h0000, 16'hFFFF});
        chk({tag, " R7 R8 stack desc"}, stack_desc_o, {16'h00CF, w2s, 16'h0000, 16'hFFFF});
        chk({tag, " R9 flag mask"}, {32'd0, flag_clr_o}, ex ? 64'd0 : 64'h0003_0200);
    endtask

    task automatic expect_fault_kept(input string tag, input logic [15:0] cs, input logic [31:0] sp,
                                     input logic [31:0] ip, input logic [31:0] fm);
        chk({tag, " R1 fault"}, {63'd0, fault_o}, 64'd1);
        chk({tag, " R1 no done"}, {63'd0, done_o}, 64'd0);
        chk({tag, " R10 code sel kept"}, {48'd0, code_sel_o}, {48'd0, cs});
        chk({tag, " R10 sp kept"}, {32'd0, sp_o}, {32'd0, sp});
        chk({tag, " R10 ip kept"}, {32'd0, ip_o}, {32'd0, ip});
        chk({tag, " R10 flag kept"}, {32'd0, flag_clr_o}, {32'd0, fm});
    endtask

    task automatic t_reset;
        chk("R12 done", {63'd0, done_o}, 0);
        chk("R12 fault", {63'd0, fault_o}, 0);
        chk("R12 code sel", {48'd0, code_sel_o}, 0);
        chk("R12 code desc", code_desc_o, 0);
        chk("R12 sp", {32'd0, sp_o}, 0);
        chk("R12 flag", {32'd0, flag_clr_o}, 0);
    endtask

    task automatic t_entry_basic;
        issue(1'b0, 1'b1, 2'd3, 16'h0013, 32'h1111_2222, 32'h3333_4444, 32'hAAAA_0001, 32'hBBBB_0002);
        expect_ok("entry", 1'b0, 16'h0010, 16'h0018, 32'h1111_2222, 32'h3333_4444);
        @(negedge clk);
        chk("R1 single-cycle done", {63'd0, done_o}, 0);
    endtask

    task automatic t_exit_basic;
        issue(1'b1, 1'b1, 2'd0, 16'h0060, 32'h1111_2222, 32'h3333_4444, 32'hCAFE_0010, 32'hF00D_0020);
        expect_ok("exit", 1'b1, 16'h0073, 16'h007B, 32'hCAFE_0010, 32'hF00D_0020);
    endtask

    task automatic t_fault_real_mode;
        issue(1'b0, 1'b0, 2'd0, 16'h0060, 32'h5, 32'h6, 32'h7, 32'h8);
        expect_fault_kept("R2 real mode", 16'h0073, 32'hCAFE_0010, 32'hF00D_0020, 32'h0);
    endtask

    task automatic t_fault_null_sel;
        issue(1'b1, 1'b1, 2'd0, 16'h0003, 32'h5, 32'h6, 32'h7, 32'h8);
        expect_fault_kept("R2 null selector", 16'h0073, 32'hCAFE_0010, 32'hF00D_0020, 32'h0);
    endtask

    task automatic t_fault_cpl;
        issue(1'b1, 1'b1, 2'd1, 16'h0060, 32'h5, 32'h6, 32'h7, 32'h8);
        expect_fault_kept("R3 exit at cpl1", 16'h0073, 32'hCAFE_0010, 32'hF00D_0020, 32'h0);
    endtask

    task automatic t_wrap;
        issue(1'b0, 1'b1, 2'd2, 16'hFFFC, 32'h0000_0100, 32'h0000_0200, 32'h9, 32'h9);
        expect_ok("R4 entry wrap", 1'b0, 16'hFFFC, 16'h0004, 32'h0000_0100, 32'h0000_0200);
        issue(1'b1, 1'b1, 2'd0, 16'hFFF8, 32'h9, 32'h9, 32'hFFFF_FFF0, 32'h8000_0000);
        expect_ok("R5 exit wrap", 1'b1, 16'h000B, 16'h0013, 32'hFFFF_FFF0, 32'h8000_0000);
    endtask

    task automatic t_busy_ignore;
        set_ops(1'b0, 1'b1, 2'd0, 16'h0100, 32'h0000_A000, 32'h0000_B000, 32'h1, 32'h2);
        req_i = 1'b1;
        @(negedge clk);
        set_ops(1'b1, 1'b0, 2'd1, 16'h0200, 32'h3, 32'h4, 32'h5, 32'h6);
        @(negedge clk);
        req_i = 1'b0;
        expect_ok("R11 first", 1'b0, 16'h0100, 16'h0108, 32'h0000_A000, 32'h0000_B000);
        @(negedge clk);
        chk("R11 no second done", {63'd0, done_o}, 0);
        chk("R11 no second fault", {63'd0, fault_o}, 0);
        chk("R11 sel kept", {48'd0, code_sel_o}, 64'h0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry_basic();
        t_exit_basic();
        t_fault_real_mode();
        t_fault_null_sel();
        t_fault_cpl();
        t_wrap();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule